// File: doc/BRIEF.md
# Priority-Pool Round-Robin Arbiter

This block decides which of several bus masters may use one shared slave. Every master carries a small priority level held in an internal table. The table is loaded from a plain input bus whenever a write strobe is high. Masters that share a level form a pool. A requester from a higher pool always beats one from a lower pool, and lower pools get no turn while a higher pool is requesting.

Ties are settled in one of two ways. In the top pool and in the bottom pool, requesters take turns in rising master-number order, and each of these two pools keeps its own record of the last master it granted. In the levels between them, the requester with the largest master number wins every time.

A grant lasts until the slave signals that the transfer is done. The grant then drops for one cycle while arbitration runs again. The grant comes out both as a one-hot vector and as a binary index.

Top module: `prio_pool_arbiter`

## Requirements
- R1: While reset is applied and in the first cycle after it, gnt_o is all zeros and gnt_idx_o is 0.
- R2: After reset, the level of master CPU_IDX (default 0) is CPU_LVL (default 2) and every other master is at level 0.
- R3: In a cycle where prio_wr_i is 1, master i's level is loaded from prio_i[i*PRIO_W +: PRIO_W]. The new level applies to every arbitration from the next cycle on.
- R4: Among the active requesters, only those at the largest level are eligible, whatever the rotation state.
- R5: In the top pool (level 2**PRIO_W-1, which is 3 by default), the winner is the first requester in that pool above the pool's last-granted master number, counting upward and wrapping past N_MASTERS-1.
- R6: The bottom pool (level 0) follows the same rotation rule as R5, using a pointer of its own.
- R7: In an intermediate pool (levels 1 and 2 by default), the requester with the highest master number wins.
- R8: A pool's last-granted pointer changes only when that pool wins a grant. Both pointers reset to N_MASTERS-1, so the first rotation in either pool starts at master 0.
- R9: A grant is issued one cycle after a request is seen while idle. It then stays unchanged, whatever the request lines do, until xfer_done_i is 1.
- R10: A cycle with an active grant and xfer_done_i=1 is followed by one cycle with no grant. Arbitration is then evaluated again in that idle cycle.
- R11: With no active request, no grant is issued, and no grant ever goes to a master that was not requesting.
- R12: gnt_o has at most one bit set, and when a bit is set, it is bit gnt_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | Request line per master |
| prio_wr_i | input | 1 | Load the level table from prio_i |
| prio_i | input | N_MASTERS*PRIO_W | Packed new levels, master i at bits i*PRIO_W +: PRIO_W |
| xfer_done_i | input | 1 | The slave has finished the granted transfer |
| gnt_o | output | N_MASTERS | One-hot grant |
| gnt_idx_o | output | IDX_W | Index of the granted master |

## Verification
The hardest situation to reach is a pair of rotation pointers that have drifted apart from each other. Then a grant in the top pool must leave the bottom pool's rotation point untouched, and the reverse must also hold. A single sweep cannot get there. So the bench writes each of the 256 level assignments for four masters in turn and plays all 16 request patterns under each one. It carries a model of both pointers across the whole run, which makes every grant depend on the full history since reset. A directed sequence that alternates between the two round-robin pools and a hold test that changes the requests in the middle of a grant come first.

// File: rtl/arb_pool_pkg.sv
package arb_pool_pkg;
    typedef enum logic [1:0] {
        ARB_NONE  = 2'd0,
        ARB_RR_HI = 2'd1,
        ARB_RR_LO = 2'd2,
        ARB_FIXED = 2'd3
    } arb_kind_e;

    function automatic arb_kind_e kind_of_level(input int lvl, input int lvl_bits);
        if (lvl == (1 << lvl_bits) - 1) return ARB_RR_HI;
        if (lvl == 0)                   return ARB_RR_LO;
        return ARB_FIXED;
    endfunction
endpackage

// File: rtl/arb_level_scan.sv
module arb_level_scan #(
    parameter int N      = 4,
    parameter int PRIO_W = 2
) (
    input  logic [N-1:0]        req,
    input  logic [N*PRIO_W-1:0] prio,
    output logic                any_req,
    output logic [PRIO_W-1:0]   top_lvl,
    output logic [N-1:0]        cand
);
    logic [PRIO_W-1:0] lvl [N];

    for (genvar g = 0; g < N; g++) begin : g_lvl
        assign lvl[g]  = prio[g*PRIO_W +: PRIO_W];
        assign cand[g] = req[g] && (lvl[g] == top_lvl);
    end

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (lvl[i] > top_lvl)) top_lvl = lvl[i];
        end
    end

    assign any_req = |req;
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        int c;
        c     = 0;
        found = 1'b0;
        pick  = '0;
        for (int off = 1; off <= N; off++) begin
            c = int'(last) + off;
            if (c >= N) c = c - N;
            if (!found && cand[IDX_W'(c)]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     cand,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) pick = IDX_W'(i);
        end
    end
endmodule

// File: rtl/prio_pool_arbiter.sv
module prio_pool_arbiter
    import arb_pool_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int PRIO_W    = 2,
    parameter int CPU_IDX   = 0,
    parameter int CPU_LVL   = 2,
    localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
    localparam int PRIO_BITS = N_MASTERS * PRIO_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 prio_wr_i,
    input  logic [PRIO_BITS-1:0] prio_i,
    input  logic                 xfer_done_i,
    output logic [N_MASTERS-1:0] gnt_o,
    output logic [IDX_W-1:0]     gnt_idx_o
);
    function automatic logic [PRIO_BITS-1:0] reset_levels();
        logic [PRIO_BITS-1:0] v;
        v = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (i == CPU_IDX) v[i*PRIO_W +: PRIO_W] = PRIO_W'(CPU_LVL);
        end
        return v;
    endfunction

    localparam logic [PRIO_BITS-1:0] PRIO_RST = reset_levels();
    localparam logic [IDX_W-1:0]     PTR_RST  = IDX_W'(N_MASTERS - 1);

    typedef struct packed {
        logic [PRIO_BITS-1:0] prio;
        logic                 busy;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W-1:0]     ptr_hi;
        logic [IDX_W-1:0]     ptr_lo;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic                 any_req;
    logic [PRIO_W-1:0]    top_lvl;
    logic [N_MASTERS-1:0] cand;
    logic                 hi_found, lo_found;
    logic [IDX_W-1:0]     hi_pick, lo_pick, fx_pick;
    arb_kind_e            kind;

    arb_level_scan #(.N(N_MASTERS), .PRIO_W(PRIO_W)) u_scan (
        .req     (req_i),
        .prio    (st_q.prio),
        .any_req (any_req),
        .top_lvl (top_lvl),
        .cand    (cand)
    );

    arb_rr_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_rr_hi (
        .cand  (cand),
        .last  (st_q.ptr_hi),
        .found (hi_found),
        .pick  (hi_pick)
    );

    arb_rr_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_rr_lo (
        .cand  (cand),
        .last  (st_q.ptr_lo),
        .found (lo_found),
        .pick  (lo_pick)
    );

    arb_fixed_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_fixed (
        .cand (cand),
        .pick (fx_pick)
    );

    always_comb begin
        kind = any_req ? kind_of_level(int'(top_lvl), PRIO_W) : ARB_NONE;
        st_d = st_q;
        if (prio_wr_i) st_d.prio = prio_i;
        if (st_q.busy) begin
            if (xfer_done_i) st_d.busy = 1'b0;
        end else begin
            unique case (kind)
                ARB_RR_HI: begin
                    st_d.busy   = hi_found;
                    st_d.idx    = hi_pick;
                    st_d.ptr_hi = hi_pick;
                end
                ARB_RR_LO: begin
                    st_d.busy   = lo_found;
                    st_d.idx    = lo_pick;
                    st_d.ptr_lo = lo_pick;
                end
                ARB_FIXED: begin
                    st_d.busy = 1'b1;
                    st_d.idx  = fx_pick;
                end
                default: st_d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prio   <= PRIO_RST;
            st_q.busy   <= 1'b0;
            st_q.idx    <= '0;
            st_q.ptr_hi <= PTR_RST;
            st_q.ptr_lo <= PTR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_gnt
        assign gnt_o[g] = st_q.busy && (st_q.idx == IDX_W'(g));
    end
    assign gnt_idx_o = st_q.busy ? st_q.idx : '0;
endmodule

// File: rtl/arb_pool_checker.sv
module arb_pool_checker #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req_i,
    input logic             xfer_done_i,
    input logic [N-1:0]     gnt_o,
    input logic [IDX_W-1:0] gnt_idx_o
);
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    a_r12_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> gnt_o[gnt_idx_o]);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !xfer_done_i) |=> $stable(gnt_o));

    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && xfer_done_i) |=> (gnt_o == '0));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));

    a_r11_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i != '0) |=> ((gnt_o & $past(req_i)) != '0));
endmodule

bind prio_pool_arbiter arb_pool_checker #(.N(N_MASTERS), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .xfer_done_i (xfer_done_i),
    .gnt_o       (gnt_o),
    .gnt_idx_o   (gnt_idx_o)
);

// File: tb/tb_prio_pool_arbiter.sv
module tb_prio_pool_arbiter;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic         prio_wr_i = 1'b0;
    logic [N*W-1:0] prio_i = '0;
    logic         xfer_done_i = 1'b0;
    logic [N-1:0] gnt_o;
    logic [1:0]   gnt_idx_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int m_prio [N];
    int m_hi = N - 1;
    int m_lo = N - 1;

    prio_pool_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_wr_i(prio_wr_i),
        .prio_i(prio_i), .xfer_done_i(xfer_done_i),
        .gnt_o(gnt_o), .gnt_idx_o(gnt_idx_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_pick(input logic [N-1:0] r);
        int top = 0;
        int pick = 0;
        int c;
        bit fnd = 0;
        for (int i = 0; i < N; i++) if (r[i] && m_prio[i] > top) top = m_prio[i];
        if (top == 3 || top == 0) begin
            for (int off = 1; off <= N; off++) begin
                c = ((top == 3 ? m_hi : m_lo) + off) % N;
                if (!fnd && r[c] && m_prio[c] == top) begin fnd = 1; pick = c; end
            end
            if (top == 3) m_hi = pick; else m_lo = pick;
        end else begin
            for (int i = 0; i < N; i++) if (r[i] && m_prio[i] == top) pick = i;
        end
        return pick;
    endfunction

    function automatic string tag_for(input logic [N-1:0] r);
        int top = 0;
        bit multi = 0;
        for (int i = 0; i < N; i++) if (r[i] && m_prio[i] > top) top = m_prio[i];
        for (int i = 0; i < N; i++) if (r[i] && m_prio[i] != top) multi = 1;
        if (multi) return "R4";
        if (top == 3) return "R5";
        if (top == 0) return "R6";
        return "R7";
    endfunction

    task automatic write_levels(input int l0, input int l1, input int l2, input int l3);
        prio_i = {W'(l3), W'(l2), W'(l1), W'(l0)};
        prio_wr_i = 1'b1;
        @(negedge clk);
        prio_wr_i = 1'b0;
        m_prio[0] = l0; m_prio[1] = l1; m_prio[2] = l2; m_prio[3] = l3;
    endtask

    task automatic trial(input logic [N-1:0] r, input string tag_in);
        int e;
        string tag;
        req_i = r;
        xfer_done_i = 1'b0;
        tag = (tag_in == "") ? tag_for(r) : tag_in;
        @(negedge clk);
        if (r == '0) begin
            check(gnt_o == '0, "R11 idle", int'(gnt_o), 0);
            return;
        end
        e = model_pick(r);
        check(gnt_o == N'(1 << e), tag, int'(gnt_o), 1 << e);
        check(int'(gnt_idx_o) == e, "R12 index", int'(gnt_idx_o), e);
        xfer_done_i = 1'b1;
        req_i = '0;
        @(negedge clk);
        xfer_done_i = 1'b0;
        check(gnt_o == '0, "R10 gap", int'(gnt_o), 0);
    endtask

    initial begin
        m_prio[0] = 2; m_prio[1] = 0; m_prio[2] = 0; m_prio[3] = 0;
        repeat (3) @(negedge clk);
        check(gnt_o == '0 && gnt_idx_o == '0, "R1 reset", int'(gnt_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gnt_o == '0 && gnt_idx_o == '0, "R1 after reset", int'(gnt_o), 0);

        // R2: reset levels put master 0 at level 2, the rest at 0
        trial(4'b1111, "R2");
        trial(4'b1110, "R2");
        trial(4'b1110, "R6");

        // R9: requests change during a held grant
        begin
            int e;
            req_i = 4'b0110;
            @(negedge clk);
            e = model_pick(4'b0110);
            check(gnt_o == N'(1 << e), "R9 start", int'(gnt_o), 1 << e);
            for (int k = 0; k < 4; k++) begin
                req_i = N'(k * 5 + 1);
                @(negedge clk);
                check(gnt_o == N'(1 << e), "R9 hold", int'(gnt_o), 1 << e);
            end
            xfer_done_i = 1'b1;
            req_i = '0;
            @(negedge clk);
            xfer_done_i = 1'b0;
            check(gnt_o == '0, "R10 release", int'(gnt_o), 0);
        end

        // R3: a written level takes effect
        write_levels(0, 3, 1, 2);
        trial(4'b1111, "R3");

        // R8: alternate between the two round-robin pools
        write_levels(3, 3, 0, 0);
        for (int k = 0; k < 6; k++) begin
            trial(4'b1111, "R8");
            trial(4'b1100, "R8");
        end

        // Sweep over all level assignments and request patterns
        for (int cfg = 0; cfg < 256; cfg++) begin
            write_levels(cfg & 3, (cfg >> 2) & 3, (cfg >> 4) & 3, (cfg >> 6) & 3);
            for (int r = 0; r < 16; r++) trial(N'(r), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule